// File: doc/BRIEF.md
# Lockable Open-Drain Port Bank

This block holds six byte-wide output registers, each bit of which controls one open-drain pad. A `1` in a register bit turns on the pad's sink and pulls the pin low. A `0` releases the pin, so an external pull-up holds it high and the pin can serve as an input. A host on a simple byte-wide register bus writes the registers at offsets 0 to 5. A read at those offsets returns the synchronised pin levels, inverted, so a released pin that floats high reads as `0`.

A control byte at offset 7 has two parts. The upper two bits form a page selector, which the block drives out so that paged register banks at higher offsets can decode it. The lower six bits are write-lock flags, one per port. Once a flag is set, host writes to that port are dropped. Only reset clears a flag.

The core contains no tristate. It drives a per-pin sink enable and receives a per-pin level from the pad ring.

Top module: `odio_bank`

## Requirements
- R1: After reset, every port register is 0 (all `pad_sink` bits low, every pin released), the page field is 0 and all lock flags are 0.
- R2: A host write to offset k (0 to 5) whose lock flag is clear loads `host_wdata` into port k on that clock edge. From then on, `pad_sink[8k+7:8k]` equals the written byte, and bit j of the byte controls pin 8k+j. A write to one port leaves the other ports unchanged.
- R3: A combinational read at offset k (0 to 5) returns the bitwise inverse of pin bits 8k+7..8k as they were sampled two rising edges earlier, through a two-flop synchroniser. The synchroniser resets to the released (high) level.
- R4: A write to offset 7 loads the page field from `host_wdata[7:6]` and ORs `host_wdata[5:0]` into the lock flags. Bit k locks port k. Writing 0 to a lock bit never clears it.
- R5: A write to a port whose lock flag is set is ignored: the port's `pad_sink` bits keep their value, and the other ports are not disturbed.
- R6: A read at offset 7 returns the page field in bits 7:6 and the lock flags in bits 5:0.
- R7: Offset 6 and offsets 8 to 15 read as 0. Writes to them change no port, no lock flag and the page field not at all.
- R8: `bank_page` always presents the current page field, and it changes on the edge that completes an offset 7 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset for read and write |
| host_wr | input | 1 | Write strobe, one byte per cycle when high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| pad_in | input | 48 | Pin levels from the pad ring, bit 8k+j is port k bit j |
| pad_sink | output | 48 | Per-pin sink enable, 1 pulls the pin low |
| bank_page | output | 2 | Page selector for neighbouring paged banks |

## Verification
The assertions take it that `host_addr`, `host_wr` and `host_wdata` are stable around each rising edge and that a write strobe means exactly one byte transfer on that edge. The pad levels are assumed to be allowed to change at any cycle, which is why the synchroniser check counts cycles since reset. The stimulus changes every input only on the falling edge. It models each pad as wired-AND: the pull-up level from the bench, forced low where the model's register drives a sink. This keeps the pin inputs consistent with what the block drives. Port, reserved and control offsets are mixed, and locks build up over the run so that later writes hit locked ports.

// File: rtl/odio_pkg.sv
`timescale 1ns/1ps
package odio_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned PAGE_W   = 2;
  localparam int unsigned CTRL_OFS = 7;

  // True when the offset addresses one of the port registers.
  function automatic logic ofs_is_port(input logic [ADDR_W-1:0] a, input int unsigned nports);
    return int'(a) < int'(nports);
  endfunction

  // True when the offset addresses the page/lock control byte.
  function automatic logic ofs_is_ctrl(input logic [ADDR_W-1:0] a);
    return int'(a) == int'(CTRL_OFS);
  endfunction

  // Lock flags are sticky: new ones are ORed into the old set.
  function automatic logic [BYTE_W-PAGE_W-1:0] merge_locks(
      input logic [BYTE_W-PAGE_W-1:0] old_l,
      input logic [BYTE_W-PAGE_W-1:0] new_l);
    return old_l | new_l;
  endfunction

  // Control byte layout: page on the top bits, locks below.
  function automatic logic [BYTE_W-1:0] pack_ctrl(
      input logic [PAGE_W-1:0] pg,
      input logic [BYTE_W-PAGE_W-1:0] lk);
    return {pg, lk};
  endfunction
endpackage

// File: rtl/odio_sync.sv
`timescale 1ns/1ps
module odio_sync #(
  parameter int unsigned W      = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

  // Cycles since reset, for the first-stage capture check.
  logic warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 1'b0;
    else warm_q <= 1'b1;
  end

  p_first_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm_q |-> (stage_q[0] == $past(d_i)));
endmodule

// File: rtl/odio_port_reg.sv
`timescale 1ns/1ps
module odio_port_reg #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit_i,
  input  logic          lock_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] q_o
);
  logic          take_w;
  logic [PW-1:0] q;

  assign take_w = wr_hit_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (take_w) q <= wdata_i;
  end

  assign q_o = q;

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && !lock_i) |=> (q == $past(wdata_i)));

  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(q));
endmodule

// File: rtl/odio_ctrl_reg.sv
`timescale 1ns/1ps
module odio_ctrl_reg #(
  parameter int unsigned NPORT  = 6,
  parameter int unsigned PAGE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_hit_i,
  input  logic [NPORT+PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0]       page_o,
  output logic [NPORT-1:0]        lock_o
);
  localparam int unsigned CW = NPORT + PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic [NPORT-1:0]  lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      lock_q <= '0;
    end else if (wr_hit_i) begin
      page_q <= wdata_i[CW-1:NPORT];
      lock_q <= odio_pkg::merge_locks(lock_q, wdata_i[NPORT-1:0]);
    end
  end

  assign page_o = page_q;
  assign lock_o = lock_q;

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  p_page_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> (page_q == $past(wdata_i[CW-1:NPORT])));
endmodule

// File: rtl/odio_rd_mux.sv
`timescale 1ns/1ps
module odio_rd_mux #(
  parameter int unsigned NPORT  = 6,
  parameter int unsigned PW     = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned PAGE_W = 2
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [NPORT*PW-1:0] lvl_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [NPORT-1:0]    lock_i,
  output logic [PW-1:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (odio_pkg::ofs_is_port(addr_i, NPORT)) begin
      for (int k = 0; k < NPORT; k++) begin
        if (int'(addr_i) == k) rdata_o = ~lvl_i[k*PW +: PW];
      end
    end else if (odio_pkg::ofs_is_ctrl(addr_i)) begin
      rdata_o = odio_pkg::pack_ctrl(page_i, lock_i);
    end
  end
endmodule

// File: rtl/odio_bank.sv
`timescale 1ns/1ps
module odio_bank #(
  parameter int unsigned NPORT  = 6,
  parameter int unsigned PW     = odio_pkg::BYTE_W,
  parameter int unsigned AW     = odio_pkg::ADDR_W,
  parameter int unsigned PAGE_W = odio_pkg::PAGE_W,
  parameter int unsigned SYNC_N = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           host_addr,
  input  logic                    host_wr,
  input  logic [PW-1:0]           host_wdata,
  output logic [PW-1:0]           host_rdata,
  input  logic [NPORT*PW-1:0]     pad_in,
  output logic [NPORT*PW-1:0]     pad_sink,
  output logic [PAGE_W-1:0]       bank_page
);
  localparam int unsigned NPIN = NPORT * PW;

  logic [NPORT-1:0] port_hit;
  logic             ctrl_hit;
  logic             addr_known;
  logic [NPORT-1:0] lock;
  logic [NPIN-1:0]  lvl_sync;

  assign ctrl_hit   = host_wr && odio_pkg::ofs_is_ctrl(host_addr);
  assign addr_known = odio_pkg::ofs_is_port(host_addr, NPORT) || odio_pkg::ofs_is_ctrl(host_addr);

  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_port
      assign port_hit[k] = host_wr && (host_addr == AW'(k));
      odio_port_reg #(.PW(PW)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit_i (port_hit[k]),
        .lock_i   (lock[k]),
        .wdata_i  (host_wdata),
        .q_o      (pad_sink[k*PW +: PW])
      );
    end
  endgenerate

  odio_ctrl_reg #(.NPORT(NPORT), .PAGE_W(PAGE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit_i (ctrl_hit),
    .wdata_i  (host_wdata),
    .page_o   (bank_page),
    .lock_o   (lock)
  );

  odio_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pad_in),
    .q_o   (lvl_sync)
  );

  odio_rd_mux #(.NPORT(NPORT), .PW(PW), .AW(AW), .PAGE_W(PAGE_W)) u_rd (
    .addr_i  (host_addr),
    .lvl_i   (lvl_sync),
    .page_i  (bank_page),
    .lock_i  (lock),
    .rdata_o (host_rdata)
  );

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({port_hit, ctrl_hit}));

  p_rsvd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !addr_known) |=> ($stable(pad_sink) && $stable(bank_page) && $stable(lock)));

  p_page_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit |=> $stable(bank_page));
endmodule

// File: tb/sim_odio_bank.sv
`timescale 1ns/1ps
module sim_odio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [47:0] pad_in = '1;
  logic [47:0] pad_sink;
  logic [1:0]  bank_page;

  always #4 clk = ~clk; // 125 MHz

  odio_bank u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pad_in(pad_in),
    .pad_sink(pad_sink), .bank_page(bank_page)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0]  m_port [6];
  logic [5:0]  m_lock;
  logic [1:0]  m_page;
  logic [47:0] m_s1, m_s2;

  function automatic logic [47:0] m_drv();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = m_port[i];
    return v;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    if (a < 4'd6) return ~m_s2[a*8 +: 8];
    if (a == 4'd7) return {m_page, m_lock};
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 6; i++) m_port[i] = 8'h00;
    m_lock = '0; m_page = '0; m_s1 = '1; m_s2 = '1;
  endtask

  // One bus cycle: drive at falling edge, compare, then advance the model.
  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d, input logic [47:0] ext);
    string rq;
    @(negedge clk);
    host_addr = a; host_wr = w; host_wdata = d;
    pad_in = ext & ~m_drv();
    #1;
    rq = (a < 4'd6) ? "R3" : ((a == 4'd7) ? "R6" : "R7");
    check(host_rdata == m_read(a), rq, 48'(host_rdata), 48'(m_read(a)));
    check(pad_sink == m_drv(), "R2", pad_sink, m_drv());
    check(bank_page == m_page, "R8", 48'(bank_page), 48'(m_page));
    @(posedge clk);
    m_s2 = m_s1; m_s1 = pad_in;
    if (w) begin
      if (a < 4'd6) begin
        if (!m_lock[a]) m_port[a] = d;
      end else if (a == 4'd7) begin
        m_page = d[7:6];
        m_lock = m_lock | d[5:0];
      end
    end
  endtask

  task automatic idle(input logic [47:0] ext);
    step(4'd0, 1'b0, 8'h00, ext);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] ext;
    logic [7:0]  saved;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    #1;
    check(pad_sink == '0, "R1", pad_sink, 48'h0);
    check(bank_page == 2'b00, "R1", 48'(bank_page), 48'h0);
    host_addr = 4'd7; #1;
    check(host_rdata == 8'h00, "R1", 48'(host_rdata), 48'h0);

    ext = '1;
    // R2: each port with several patterns
    for (int k = 0; k < 6; k++) step(4'(k), 1'b1, 8'hA5 ^ 8'(k), ext);
    for (int k = 0; k < 6; k++) step(4'(k), 1'b0, 8'h00, ext);
    for (int k = 0; k < 6; k++) step(4'(k), 1'b1, 8'h0F << k, ext);
    // R3: external levels toggle, read back inverted after sync
    ext = 48'h00FF_F0F0_3C3C;
    for (int k = 0; k < 6; k++) step(4'(k), 1'b1, 8'h00, ext);
    repeat (3) idle(ext);
    for (int k = 0; k < 6; k++) step(4'(k), 1'b0, 8'h00, ext);
    ext = 48'hFFFF_0000_AAAA;
    for (int k = 0; k < 6; k++) step(4'(k), 1'b0, 8'h00, ext);
    // R7: reserved offsets
    step(4'd6, 1'b1, 8'hFF, ext);
    step(4'd12, 1'b1, 8'hFF, ext);
    step(4'd15, 1'b0, 8'h00, ext);
    // R4 / R8: page without locks, then locks on ports 2 and 4
    step(4'd7, 1'b1, 8'b10_000000, ext);
    step(4'd3, 1'b1, 8'h5A, ext);
    step(4'd2, 1'b1, 8'h3C, ext);
    step(4'd7, 1'b1, 8'b01_010100, ext);
    idle(ext);
    host_addr = 4'd7; #1;
    check(host_rdata == 8'b01_010100, "R4", 48'(host_rdata), 48'h54);
    // R4: writing zeros must not clear locks
    step(4'd7, 1'b1, 8'b11_000000, ext);
    host_addr = 4'd7; #1;
    check(host_rdata[5:0] == 6'b010100, "R4", 48'(host_rdata), 48'h14);
    // R5: locked port ignores write, neighbour still writable
    saved = pad_sink[23:16];
    step(4'd2, 1'b1, 8'hC3, ext);
    step(4'd1, 1'b1, 8'h81, ext);
    idle(ext);
    check(pad_sink[23:16] == saved, "R5", 48'(pad_sink[23:16]), 48'(saved));
    check(pad_sink[15:8] == 8'h81, "R5", 48'(pad_sink[15:8]), 48'h81);
    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] a;
      if ((n % 37) == 0) ext = {$urandom, $urandom};
      a = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(0, 5)) : 4'($urandom_range(6, 15));
      if (a == 4'd7 && $urandom_range(0, 3) != 0) a = 4'd0;
      step(a, 1'($urandom_range(0, 1)), 8'($urandom), ext);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule